// File: doc/BRIEF.md
# Control endpoint OUT handshake and toggle controller

This block decides which handshake the OUT side of a USB device's control endpoint returns, and it keeps that side's data toggle. Firmware reaches it through a small register port at two addresses. The control byte carries a NAK-forcing flag, a STALL-forcing flag, a read-only copy of the toggle, and two write-one strobes that clear or set the toggle. A second address exposes the setup-received flag, which firmware clears by writing a one to it.

A separate packet engine drives the other side. It signals transaction start, transaction end (with the data PID of the received packet), SETUP token arrival and SETUP stage completion. At transaction start the block samples its flags and holds the chosen handshake for the whole transaction. A write that lands while a transaction is running therefore takes effect only at the next transaction. SETUP completion locks the endpoint into NAK and out of STALL until firmware acknowledges the setup-received flag.

Top module: `ep0_out_hs_ctrl`

## Requirements
- R1: `handshake_o` uses the encoding ACK = 0, NAK = 1, STALL = 2. It is captured on the clock edge where `xact_start_i` is high, from the flag values held just before that edge, and it never takes the value 3.
- R2: If the STALL flag (control bit 6) is 1 at transaction start, the handshake is STALL, whatever the NAK flag holds.
- R3: If the NAK flag (control bit 7) is 1 and the STALL flag is 0 at transaction start, the handshake is NAK. If both flags are 0, the handshake is ACK.
- R4: A pulse on `setup_done_i` sets the setup-received flag (bit 0 at address 1) and sets the NAK flag. While the setup-received flag is 1, control writes leave the NAK flag at 1.
- R5: A pulse on `setup_done_i` clears the STALL flag. While the setup-received flag is 1, control writes leave the STALL flag at 0.
- R6: A pulse on `setup_tok_i` sets the toggle to 1. This takes priority over a toggle strobe written in the same cycle.
- R7: Writing 1 to control bit 1 clears the toggle, and writing 1 to bit 0 sets it. If both are 1, the clear wins. Both bits read as 0. Bit 2 reads the current toggle. A write to bit 2 has no effect.
- R8: A control write made while a transaction is in progress leaves `handshake_o` unchanged until the next `xact_start_i`.
- R9: At `xact_end_i`, if the handshake is ACK and `data_pid_i` equals the toggle, `accept_o` is 1 and the toggle inverts. If the PID does not match, or the handshake is NAK or STALL, `accept_o` is 0 and the toggle is unchanged.
- R10: Writing 1 to bit 0 at address 1 clears the setup-received flag, and writing 0 there has no effect. If `setup_done_i` arrives in the same cycle, the flag stays set.
- R11: After reset, all flags and the toggle are 0 and `handshake_o` is ACK. Control bits 5:3 always read 0, and address 1 reads 0 in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 selects the control byte, 1 selects the setup flag |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| xact_start_i | input | 1 | An OUT transaction begins |
| xact_end_i | input | 1 | An OUT data packet has been received |
| data_pid_i | input | 1 | Data PID parity of the received packet, valid with `xact_end_i` |
| setup_tok_i | input | 1 | A SETUP token was received |
| setup_done_i | input | 1 | The SETUP stage has completed |
| handshake_o | output | 2 | Handshake for the current transaction |
| accept_o | output | 1 | The current packet is accepted and its toggle advances |
| setup_flag_o | output | 1 | Setup-received flag |

## Verification
A wrong flag value shows up on `reg_rdata_o` in the cycle after the write. It shows up again on `handshake_o` one edge after the next transaction start. A toggle fault shows up on bit 2 at once, and it also flips `accept_o` during the next ACKed packet. That fault then propagates, so every later comparison of the PID with the toggle goes wrong. A leak past the SETUP lock or past the deferral shows up as a changed handshake inside a transaction, or as a readback that left the forced value. The sweeps cover all 256 write values both with the lock clear and with it set.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_NAK   = 7;
  localparam int BIT_STALL = 6;
  localparam int BIT_TGL   = 2;
  localparam int BIT_TCLR  = 1;
  localparam int BIT_TSET  = 0;
  localparam int BIT_SFLAG = 0;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;
endpackage

// File: rtl/ep0_flag_regs.sv
module ep0_flag_regs
  import ep0_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_setup_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             setup_done_i,
  output logic             nak_o,
  output logic             stall_o,
  output logic             setup_flag_o,
  output logic             tclr_o,
  output logic             tset_o
);
  logic nak_q, stall_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nak_q   <= 1'b0;
      stall_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (setup_done_i)                       flag_q <= 1'b1;
      else if (wr_setup_i && wdata_i[BIT_SFLAG]) flag_q <= 1'b0;

      // SETUP lock: flags frozen while the setup-received flag is up
      if (setup_done_i) begin
        nak_q   <= 1'b1;
        stall_q <= 1'b0;
      end else if (wr_ctrl_i && !flag_q) begin
        nak_q   <= wdata_i[BIT_NAK];
        stall_q <= wdata_i[BIT_STALL];
      end
    end
  end

  assign nak_o        = nak_q;
  assign stall_o      = stall_q;
  assign setup_flag_o = flag_q;
  assign tclr_o       = wr_ctrl_i && wdata_i[BIT_TCLR];
  assign tset_o       = wr_ctrl_i && wdata_i[BIT_TSET];
endmodule

// File: rtl/ep0_hs_latch.sv
module ep0_hs_latch
  import ep0_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic nak_i,
  input  logic stall_i,
  output hs_e  hs_o
);
  hs_e hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hs_q <= HS_ACK;
    else if (start_i) hs_q <= stall_i ? HS_STALL : (nak_i ? HS_NAK : HS_ACK);
  end

  assign hs_o = hs_q;
endmodule

// File: rtl/ep0_toggle.sv
module ep0_toggle
  import ep0_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_tok_i,
  input  logic tclr_i,
  input  logic tset_i,
  input  logic xact_end_i,
  input  logic data_pid_i,
  input  hs_e  hs_i,
  output logic toggle_o,
  output logic accept_o
);
  logic tgl_q;

  assign accept_o = xact_end_i && (hs_i == HS_ACK) && (data_pid_i == tgl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tgl_q <= 1'b0;
    else if (setup_tok_i) tgl_q <= 1'b1;
    else if (tclr_i)      tgl_q <= 1'b0;
    else if (tset_i)      tgl_q <= 1'b1;
    else if (accept_o)    tgl_q <= ~tgl_q;
  end

  assign toggle_o = tgl_q;
endmodule

// File: rtl/ep0_out_hs_ctrl.sv
module ep0_out_hs_ctrl
  import ep0_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             xact_start_i,
  input  logic             xact_end_i,
  input  logic             data_pid_i,
  input  logic             setup_tok_i,
  input  logic             setup_done_i,
  output logic [1:0]       handshake_o,
  output logic             accept_o,
  output logic             setup_flag_o
);
  logic nak_q, stall_q, setup_flag_q, toggle_q, tclr, tset;
  hs_e  hs;

  ep0_flag_regs i_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctrl_i    (reg_wr_i && !reg_addr_i),
    .wr_setup_i   (reg_wr_i && reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .setup_done_i (setup_done_i),
    .nak_o        (nak_q),
    .stall_o      (stall_q),
    .setup_flag_o (setup_flag_q),
    .tclr_o       (tclr),
    .tset_o       (tset)
  );

  ep0_hs_latch i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (xact_start_i),
    .nak_i   (nak_q),
    .stall_i (stall_q),
    .hs_o    (hs)
  );

  ep0_toggle i_toggle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .setup_tok_i (setup_tok_i),
    .tclr_i      (tclr),
    .tset_i      (tset),
    .xact_end_i  (xact_end_i),
    .data_pid_i  (data_pid_i),
    .hs_i        (hs),
    .toggle_o    (toggle_q),
    .accept_o    (accept_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i) begin
      reg_rdata_o[BIT_SFLAG] = setup_flag_q;
    end else begin
      reg_rdata_o[BIT_NAK]   = nak_q;
      reg_rdata_o[BIT_STALL] = stall_q;
      reg_rdata_o[BIT_TGL]   = toggle_q;
    end
  end

  assign handshake_o  = hs;
  assign setup_flag_o = setup_flag_q;
endmodule

// File: rtl/ep0_hs_chk.sv
module ep0_hs_chk
  import ep0_hs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xact_start_i,
  input logic             setup_tok_i,
  input logic             setup_flag_q,
  input logic             nak_q,
  input logic             stall_q,
  input logic             toggle_q,
  input logic [1:0]       handshake_o,
  input logic             reg_addr_i,
  input logic [REG_W-1:0] reg_rdata_o
);
  assert_no_code3_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handshake_o != 2'd3);

  assert_stall_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_start_i && stall_q) |=> handshake_o == 2'd2);

  assert_nak_hs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_start_i && nak_q && !stall_q) |=> handshake_o == 2'd1);

  assert_lock_nak_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_flag_q |-> nak_q);

  assert_lock_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_flag_q |-> !stall_q);

  assert_tok_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_tok_i |=> toggle_q);

  assert_hold_hs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xact_start_i |=> $stable(handshake_o));

  assert_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_addr_i |-> (reg_rdata_o[5:3] == 3'b0 && reg_rdata_o[1:0] == 2'b0));
endmodule

bind ep0_out_hs_ctrl ep0_hs_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xact_start_i (xact_start_i),
  .setup_tok_i  (setup_tok_i),
  .setup_flag_q (setup_flag_q),
  .nak_q        (nak_q),
  .stall_q      (stall_q),
  .toggle_q     (toggle_q),
  .handshake_o  (handshake_o),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o)
);

// File: tb/test_ep0_out_hs_ctrl.sv
`timescale 1ns/1ps
module test_ep0_out_hs_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       xact_start_i = 1'b0, xact_end_i = 1'b0, data_pid_i = 1'b0;
  logic       setup_tok_i = 1'b0, setup_done_i = 1'b0;
  logic [1:0] handshake_o;
  logic       accept_o, setup_flag_o;

  int nvec = 0, nfail = 0;
  logic m_nak = 0, m_stall = 0, m_flag = 0, m_tgl = 0;
  logic [1:0] m_hs = 0;

  always #2 clk_i = ~clk_i;

  ep0_out_hs_ctrl i_ep0_out_hs_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [7:0] exp_ctrl();
    return {m_nak, m_stall, 3'b000, m_tgl, 2'b00};
  endfunction

  task automatic model_wr_ctrl(input logic [7:0] d);
    if (!m_flag) begin m_nak = d[7]; m_stall = d[6]; end
    if (d[1]) m_tgl = 0; else if (d[0]) m_tgl = 1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick();
    reg_wr_i = 1'b0;
    if (!a) model_wr_ctrl(d);
    else if (d[0]) m_flag = 0;
  endtask

  task automatic rd_chk(input string req, input logic a);
    reg_addr_i = a; #0.5;
    chk(req, reg_rdata_o, a ? {7'b0, m_flag} : exp_ctrl());
  endtask

  task automatic setup_evt();
    setup_done_i = 1'b1; setup_tok_i = 1'b1;
    tick();
    setup_done_i = 1'b0; setup_tok_i = 1'b0;
    m_flag = 1; m_nak = 1; m_stall = 0; m_tgl = 1;
  endtask

  // one transaction; optional control write while it runs
  task automatic xact(input logic pid, input logic mid, input logic [7:0] md);
    logic exp_acc;
    xact_start_i = 1'b1;
    tick();
    xact_start_i = 1'b0;
    m_hs = m_stall ? 2'd2 : (m_nak ? 2'd1 : 2'd0);
    chk("R1/R2/R3 hs", handshake_o, m_hs);
    if (mid) begin
      wr(1'b0, md);
      chk("R8 deferred", handshake_o, m_hs);
      rd_chk("R8 write landed", 1'b0);
    end
    xact_end_i = 1'b1; data_pid_i = pid; #0.5;
    exp_acc = (m_hs == 2'd0) && (pid == m_tgl);
    chk("R9 accept", accept_o, exp_acc);
    tick();
    xact_end_i = 1'b0;
    if (exp_acc) m_tgl = ~m_tgl;
    rd_chk("R9 toggle", 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #5 rst_ni = 1'b1;
    tick();
    // R11 reset state
    rd_chk("R11 ctrl reset", 1'b0);
    rd_chk("R11 flag reset", 1'b1);
    chk("R11 hs reset", handshake_o, 0);

    // R2 R3 R7 R9 R11: all control values with lock clear, then a transaction
    for (int i = 0; i < 256; i++) begin
      wr(1'b0, 8'(i));
      rd_chk("R7/R11 readback", 1'b0);
      xact(i[2] ^ i[5], 1'b0, 8'h00);
    end

    // R8: flags changed mid-transaction
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        wr(1'b0, 8'(i << 6));
        xact(j[0], 1'b1, 8'(j << 6));
        xact(j[1], 1'b0, 8'h00);
      end
    end

    // R4 R5 R6: SETUP lock
    wr(1'b0, 8'h42);
    setup_evt();
    rd_chk("R4 flag set", 1'b1);
    rd_chk("R4/R5/R6 locked ctrl", 1'b0);
    chk("R4 flag port", setup_flag_o, 1);
    for (int i = 0; i < 256; i++) begin
      wr(1'b0, 8'(i));
      rd_chk("R4/R5 lock holds", 1'b0);
      if (i % 16 == 0) xact(i[4], 1'b0, 8'h00);
    end

    // R6: SETUP token beats toggle clear in the same cycle
    wr(1'b0, 8'h02);
    reg_addr_i = 1'b0; reg_wdata_i = 8'h02; reg_wr_i = 1'b1; setup_tok_i = 1'b1;
    tick();
    reg_wr_i = 1'b0; setup_tok_i = 1'b0; m_tgl = 1;
    rd_chk("R6 token priority", 1'b0);

    // R10: write 0 ignored, setup_done wins, write 1 clears
    wr(1'b1, 8'hFE);
    rd_chk("R10 zero write", 1'b1);
    reg_addr_i = 1'b1; reg_wdata_i = 8'h01; reg_wr_i = 1'b1; setup_done_i = 1'b1;
    tick();
    reg_wr_i = 1'b0; setup_done_i = 1'b0;
    m_nak = 1; m_stall = 0;
    rd_chk("R10 set wins", 1'b1);
    wr(1'b1, 8'h01);
    rd_chk("R10 cleared", 1'b1);
    rd_chk("R4 nak stays after clear", 1'b0);
    wr(1'b0, 8'h40);
    rd_chk("R5 stall after unlock", 1'b0);
    xact(1'b0, 1'b0, 8'h00);
    wr(1'b0, 8'h00);
    xact(m_tgl, 1'b0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule